// File: doc/BRIEF.md
# Standby Spare Switch Controller

This block sits in front of a bank of identical redundant modules and decides which of them feeds the system. Every module delivers a result word, a fault indication from its own detector (a code check or a plausibility check, for example) and a heartbeat pulse. In simplex operation one module is running and its word is passed to the output. When that module reports a fault, it is marked failed and the next healthy module in ascending index order takes over. The block tells each module through a run-enable whether it is in service, so spares can stay unpowered until they are needed.

Each module has a built-in watchdog. The watchdog counts only while the module is running, and the module's heartbeat restarts it. If the count reaches the timeout, the module is treated as faulty. In pair mode the block runs two modules together and compares their words. Any difference, or a fault on either module, retires both of them, because the comparison cannot show which one is wrong. The next two healthy modules replace them. When only one healthy module remains, the block falls back to simplex. When none remains, it raises a system-failed flag.

Control is a three-state machine. The states are SIMPLEX (one module in service), PAIR (two modules compared) and FAILED (nothing left; terminal until reset). The transitions are:
- SIMPLEX to SIMPLEX on a fault when a healthy spare is left.
- SIMPLEX to FAILED on a fault when no healthy spare is left.
- PAIR to PAIR on a fault when two healthy spares are left.
- PAIR to SIMPLEX on a fault when exactly one healthy spare is left.
- PAIR to FAILED on a fault when no healthy spare is left.

Reset enters PAIR or SIMPLEX according to the mode request.

Top module: `standby_switch`

## Requirements
- R1: While reset is held, the mode request is sampled on each clock edge. After reset, sel_a is 0, faulty_map is all zero, sys_failed and reconfig are 0, and the block is in PAIR (pair_active=1, sel_b=1) if the request was 1 at the last reset edge, otherwise in SIMPLEX (sel_b=0).
- R2: Outside FAILED, sys_data equals the word of module sel_a, which is mod_data bits [i*DATA_W +: DATA_W] for module i. mod_run has exactly the bit of sel_a set in SIMPLEX, and the bits of sel_a and sel_b set in PAIR.
- R3: In SIMPLEX, if mod_err of the running module is 1 at a clock edge, that edge sets its faulty_map bit and moves sel_a to the lowest-indexed module not marked faulty.
- R4: mod_err and mod_beat of modules that are not running have no effect on faulty_map or on the selection.
- R5: A running module's watchdog is cleared at every edge where its mod_beat is 1 and advances at every other edge. The module counts as faulty in the cycle after WD_TIMEOUT consecutive edges without a beat, and it is retired at the following edge.
- R6: faulty_map bits are only ever set, never cleared, except by reset. A module marked faulty is never run again.
- R7: In PAIR, a fault on either running module, or a difference between their words, marks both modules faulty at the next edge. sel_a and sel_b then become the two lowest-indexed healthy modules.
- R8: In PAIR, if exactly one healthy module remains after such a fault, the block enters SIMPLEX on that module (pair_active=0, sel_a=sel_b=that module).
- R9: If no healthy module remains after a fault, the block enters FAILED. In FAILED, sys_failed=1, sys_valid=0, sys_data=0 and mod_run=0 until reset, whatever the inputs.
- R10: sys_valid is 0 in any cycle in which the running selection reports a fault (detector, watchdog or pair mismatch), and 1 otherwise outside FAILED.
- R11: Changes of the mode request after reset have no effect.
- R12: reconfig is 1 for exactly the cycle after each edge at which a fault was taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pair_mode_req | input | 1 | Selects pair mode; sampled only during reset |
| mod_data | input | N_MOD*DATA_W | Result words, module i at [i*DATA_W +: DATA_W] |
| mod_err | input | N_MOD | Per-module detector fault indication |
| mod_beat | input | N_MOD | Per-module heartbeat pulse |
| sys_data | output | DATA_W | Selected result word |
| sys_valid | output | 1 | Selected word is fault-free this cycle |
| sys_failed | output | 1 | No healthy module remains |
| sel_a | output | IW | Primary running module index |
| sel_b | output | IW | Second running module index (equals sel_a in simplex) |
| pair_active | output | 1 | Pair comparison in force |
| mod_run | output | N_MOD | Run enable per module |
| faulty_map | output | N_MOD | Sticky faulty flag per module |
| reconfig | output | 1 | One-cycle pulse after a reconfiguration |

## Verification
The simplex run gives every module a distinct word, so a wrong selector or a wrong retirement shows up as a wrong value. Detector faults are injected on running and on idle modules, which separates "ignored" from "taken". The watchdog is starved once for one cycle short of the timeout and once for the full timeout, which pins down the exact expiry edge. The pair run keeps the words identical until a single-bit difference is injected, then starves the second pair to force the fall-back to the last module and finally the terminal failed state. A behavioural model checks all outputs every cycle.

// File: rtl/sbs_pkg.sv
`timescale 1ns/1ps
package sbs_pkg;
    typedef enum logic [1:0] {
        ST_SIMPLEX = 2'd0,
        ST_PAIR    = 2'd1,
        ST_FAILED  = 2'd2
    } sbs_state_e;
endpackage

// File: rtl/sbs_wdog.sv
`timescale 1ns/1ps
// Per-module watchdog: counts edges without a heartbeat while the module runs.
module sbs_wdog #(
    parameter int TIMEOUT = 16,
    localparam int CW = $clog2(TIMEOUT + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic beat,
    output logic expired
);
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n || !run || beat) begin
            cnt_q <= '0;
        end else if (cnt_q != CW'(TIMEOUT)) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign expired = (cnt_q == CW'(TIMEOUT));
endmodule

// File: rtl/sbs_mux.sv
`timescale 1ns/1ps
// N-to-1 word selector.
module sbs_mux #(
    parameter int N_MOD  = 4,
    parameter int DATA_W = 8,
    parameter int IW     = 2
) (
    input  logic [N_MOD*DATA_W-1:0] data_flat,
    input  logic [IW-1:0]           sel,
    output logic [DATA_W-1:0]       word
);
    logic [DATA_W-1:0] words [N_MOD];

    for (genvar g = 0; g < N_MOD; g++) begin : g_slice
        assign words[g] = data_flat[g*DATA_W +: DATA_W];
    end

    always_comb begin
        word = '0;
        for (int i = 0; i < N_MOD; i++) begin
            if (sel == IW'(i)) word = words[i];
        end
    end
endmodule

// File: rtl/sbs_pick.sv
`timescale 1ns/1ps
// Finds the two lowest-indexed healthy modules.
module sbs_pick #(
    parameter int N_MOD = 4,
    parameter int IW    = 2
) (
    input  logic [N_MOD-1:0] healthy,
    output logic             first_ok,
    output logic [IW-1:0]    first_idx,
    output logic             second_ok,
    output logic [IW-1:0]    second_idx
);
    always_comb begin
        first_ok   = 1'b0;
        second_ok  = 1'b0;
        first_idx  = '0;
        second_idx = '0;
        for (int i = 0; i < N_MOD; i++) begin
            if (healthy[i]) begin
                if (!first_ok) begin
                    first_ok  = 1'b1;
                    first_idx = IW'(i);
                end else if (!second_ok) begin
                    second_ok  = 1'b1;
                    second_idx = IW'(i);
                end
            end
        end
    end
endmodule

// File: rtl/standby_switch.sv
`timescale 1ns/1ps
module standby_switch
    import sbs_pkg::*;
#(
    parameter int N_MOD      = 4,
    parameter int DATA_W     = 8,
    parameter int WD_TIMEOUT = 16,
    localparam int IW = (N_MOD > 1) ? $clog2(N_MOD) : 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    pair_mode_req,
    input  logic [N_MOD*DATA_W-1:0] mod_data,
    input  logic [N_MOD-1:0]        mod_err,
    input  logic [N_MOD-1:0]        mod_beat,
    output logic [DATA_W-1:0]       sys_data,
    output logic                    sys_valid,
    output logic                    sys_failed,
    output logic [IW-1:0]           sel_a,
    output logic [IW-1:0]           sel_b,
    output logic                    pair_active,
    output logic [N_MOD-1:0]        mod_run,
    output logic [N_MOD-1:0]        faulty_map,
    output logic                    reconfig
);
    localparam bit PAIR_OK = (N_MOD > 1);

    sbs_state_e        state_q, state_d;
    logic [IW-1:0]     sela_q, sela_d, selb_q, selb_d;
    logic [N_MOD-1:0]  faulty_q, faulty_d;
    logic [N_MOD-1:0]  run_mask, wd_exp;
    logic              reconf_q;
    logic [DATA_W-1:0] word_a, word_b;
    logic              cur_fault;
    logic              first_ok, second_ok;
    logic [IW-1:0]     first_idx, second_idx;

    // Run enables follow the state and selection registers.
    always_comb begin
        run_mask = '0;
        for (int i = 0; i < N_MOD; i++) begin
            unique case (state_q)
                ST_SIMPLEX: run_mask[i] = (sela_q == IW'(i));
                ST_PAIR:    run_mask[i] = (sela_q == IW'(i)) || (selb_q == IW'(i));
                default:    run_mask[i] = 1'b0;
            endcase
        end
    end

    for (genvar g = 0; g < N_MOD; g++) begin : g_wd
        sbs_wdog #(.TIMEOUT(WD_TIMEOUT)) u_wdog (
            .clk     (clk),
            .rst_n   (rst_n),
            .run     (run_mask[g]),
            .beat    (mod_beat[g]),
            .expired (wd_exp[g])
        );
    end

    sbs_mux #(.N_MOD(N_MOD), .DATA_W(DATA_W), .IW(IW)) u_mux_a (
        .data_flat (mod_data),
        .sel       (sela_q),
        .word      (word_a)
    );

    sbs_mux #(.N_MOD(N_MOD), .DATA_W(DATA_W), .IW(IW)) u_mux_b (
        .data_flat (mod_data),
        .sel       (selb_q),
        .word      (word_b)
    );

    // Fault seen on the running selection this cycle.
    always_comb begin
        unique case (state_q)
            ST_SIMPLEX: cur_fault = |(run_mask & (mod_err | wd_exp));
            ST_PAIR:    cur_fault = (|(run_mask & (mod_err | wd_exp))) || (word_a != word_b);
            default:    cur_fault = 1'b0;
        endcase
    end

    assign faulty_d = faulty_q | (cur_fault ? run_mask : '0);

    sbs_pick #(.N_MOD(N_MOD), .IW(IW)) u_pick (
        .healthy    (~faulty_d),
        .first_ok   (first_ok),
        .first_idx  (first_idx),
        .second_ok  (second_ok),
        .second_idx (second_idx)
    );

    // Next-state logic.
    always_comb begin
        state_d = state_q;
        sela_d  = sela_q;
        selb_d  = selb_q;
        unique case (state_q)
            ST_SIMPLEX: begin
                if (cur_fault) begin
                    if (first_ok) begin
                        sela_d = first_idx;
                        selb_d = first_idx;
                    end else begin
                        state_d = ST_FAILED;
                    end
                end
            end
            ST_PAIR: begin
                if (cur_fault) begin
                    if (second_ok) begin
                        sela_d = first_idx;
                        selb_d = second_idx;
                    end else if (first_ok) begin
                        state_d = ST_SIMPLEX;
                        sela_d  = first_idx;
                        selb_d  = first_idx;
                    end else begin
                        state_d = ST_FAILED;
                    end
                end
            end
            ST_FAILED: state_d = ST_FAILED;
            default:   state_d = ST_FAILED;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= (pair_mode_req && PAIR_OK) ? ST_PAIR : ST_SIMPLEX;
            sela_q   <= '0;
            selb_q   <= (pair_mode_req && PAIR_OK) ? IW'(1) : '0;
            faulty_q <= '0;
            reconf_q <= 1'b0;
        end else begin
            state_q  <= state_d;
            sela_q   <= sela_d;
            selb_q   <= selb_d;
            faulty_q <= faulty_d;
            reconf_q <= cur_fault;
        end
    end

    // Outputs.
    always_comb begin
        sys_data    = '0;
        sys_valid   = 1'b0;
        sys_failed  = 1'b0;
        pair_active = 1'b0;
        unique case (state_q)
            ST_SIMPLEX: begin
                sys_data  = word_a;
                sys_valid = !cur_fault;
            end
            ST_PAIR: begin
                sys_data    = word_a;
                sys_valid   = !cur_fault;
                pair_active = 1'b1;
            end
            default: sys_failed = 1'b1;
        endcase
    end

    assign sel_a      = sela_q;
    assign sel_b      = selb_q;
    assign mod_run    = run_mask;
    assign faulty_map = faulty_q;
    assign reconfig   = reconf_q;
endmodule

// File: rtl/sbs_chk.sv
`timescale 1ns/1ps
module sbs_chk #(
    parameter int N_MOD = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic [N_MOD-1:0] mod_run,
    input logic [N_MOD-1:0] faulty_map,
    input logic             sys_failed,
    input logic             sys_valid,
    input logic             pair_active,
    input logic             reconfig
);
    AST_SIMPLEX_ONE_RUNNING: assert property (@(posedge clk) disable iff (!rst_n)
        (!sys_failed && !pair_active) |-> ($countones(mod_run) == 1)); // R2
    AST_PAIR_TWO_RUNNING: assert property (@(posedge clk) disable iff (!rst_n)
        pair_active |-> ($countones(mod_run) == 2)); // R7
    AST_RUN_ONLY_HEALTHY: assert property (@(posedge clk) disable iff (!rst_n)
        ((mod_run & faulty_map) == '0)); // R6
    AST_FAULTY_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (($past(faulty_map) & ~faulty_map) == '0)); // R6
    AST_FAILED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        sys_failed |-> (!sys_valid && (mod_run == '0))); // R9
    AST_FAILED_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(sys_failed)) |-> sys_failed); // R9
    AST_RECONFIG_MARKS: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && reconfig) |-> (faulty_map != $past(faulty_map))); // R12
endmodule

bind standby_switch sbs_chk #(.N_MOD(N_MOD)) u_sbs_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .mod_run     (mod_run),
    .faulty_map  (faulty_map),
    .sys_failed  (sys_failed),
    .sys_valid   (sys_valid),
    .pair_active (pair_active),
    .reconfig    (reconfig)
);

// File: tb/standby_switch_test.sv
`timescale 1ns/1ps
module standby_switch_test;
    localparam int N  = 5;
    localparam int W  = 8;
    localparam int T  = 8;
    localparam int IW = 3;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           pair_req = 1'b0;
    logic [N*W-1:0] data = '0;
    logic [N-1:0]   err = '0;
    logic [N-1:0]   beat = '1;
    logic [W-1:0]   sys_data;
    logic           sys_valid, sys_failed, pair_active, reconfig;
    logic [IW-1:0]  sel_a, sel_b;
    logic [N-1:0]   mod_run, faulty_map;

    standby_switch #(.N_MOD(N), .DATA_W(W), .WD_TIMEOUT(T)) uut (
        .clk(clk), .rst_n(rst_n), .pair_mode_req(pair_req),
        .mod_data(data), .mod_err(err), .mod_beat(beat),
        .sys_data(sys_data), .sys_valid(sys_valid), .sys_failed(sys_failed),
        .sel_a(sel_a), .sel_b(sel_b), .pair_active(pair_active),
        .mod_run(mod_run), .faulty_map(faulty_map), .reconfig(reconfig)
    );

    always #2 clk = ~clk;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    // Behavioural reference: 0 simplex, 1 pair, 2 failed.
    int         m_state = 0;
    int         m_a = 0, m_b = 0;
    logic [N-1:0] m_faulty = '0;
    int         m_cnt [N];
    bit         m_rec = 0;
    int         healthy_q [$];

    function automatic logic [W-1:0] word(int i);
        return data[i*W +: W];
    endfunction

    function automatic logic [N-1:0] m_run();
        logic [N-1:0] r = '0;
        if (m_state == 0) r[m_a] = 1'b1;
        if (m_state == 1) begin r[m_a] = 1'b1; r[m_b] = 1'b1; end
        return r;
    endfunction

    function automatic bit m_fault();
        logic [N-1:0] r = m_run();
        bit f = 0;
        if (m_state == 2) return 0;
        for (int i = 0; i < N; i++)
            if (r[i] && (err[i] || m_cnt[i] == T)) f = 1;
        if (m_state == 1 && word(m_a) != word(m_b)) f = 1;
        return f;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_state  = pair_req ? 1 : 0;
            m_a      = 0;
            m_b      = pair_req ? 1 : 0;
            m_faulty = '0;
            m_rec    = 0;
            for (int i = 0; i < N; i++) m_cnt[i] = 0;
        end else begin
            logic [N-1:0] r;
            bit f;
            r = m_run();
            f = m_fault();
            for (int i = 0; i < N; i++) begin
                if (!r[i] || beat[i]) m_cnt[i] = 0;
                else if (m_cnt[i] < T) m_cnt[i]++;
            end
            m_rec = f;
            if (f) begin
                m_faulty = m_faulty | r;
                healthy_q.delete();
                for (int i = 0; i < N; i++) if (!m_faulty[i]) healthy_q.push_back(i);
                if (healthy_q.size() == 0) m_state = 2;
                else if (m_state == 1 && healthy_q.size() >= 2) begin
                    m_a = healthy_q[0]; m_b = healthy_q[1];
                end else begin
                    m_state = 0; m_a = healthy_q[0]; m_b = healthy_q[0];
                end
            end
        end
    end

    task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic cmp_all();
        bit f = m_fault();
        chk("R2",  "sys_data",    sys_data,    (m_state == 2) ? '0 : word(m_a));
        chk("R2",  "mod_run",     mod_run,     m_run());
        chk("R10", "sys_valid",   sys_valid,   (m_state != 2) && !f);
        chk("R9",  "sys_failed",  sys_failed,  m_state == 2);
        chk("R7",  "pair_active", pair_active, m_state == 1);
        chk("R3",  "sel_a",       sel_a,       m_a);
        chk("R7",  "sel_b",       sel_b,       m_b);
        chk("R6",  "faulty_map",  faulty_map,  m_faulty);
        chk("R12", "reconfig",    reconfig,    m_rec);
    endtask

    task automatic step();
        @(negedge clk);
        if (rst_n) cmp_all();
    endtask

    task automatic report();
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    task automatic do_reset(bit pr);
        rst_n = 1'b0; pair_req = pr; err = '0; beat = '1;
        repeat (3) step();
        rst_n = 1'b1;
        pair_req = 1'b0;
        step();
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL R1..all watchdog expired actual=running expected=finished");
        report();
    end

    initial begin
        for (int i = 0; i < N; i++) data[i*W +: W] = W'(8'h11 * (i + 1));
        // ---- simplex run ----
        do_reset(1'b0);
        chk("R1", "reset sel_a", sel_a, 0);
        chk("R1", "reset faulty_map", faulty_map, 0);
        chk("R1", "reset pair_active", pair_active, 0);
        chk("R1", "reset sys_failed", sys_failed, 0);
        for (int k = 0; k < 4; k++) begin
            for (int i = 0; i < N; i++) data[i*W +: W] = W'(8'h20 * i + k + 3);
            step();
            chk("R2", "sys_data of module 0", sys_data, word(0));
        end
        err[3] = 1'b1; beat[4] = 1'b0; step(); step(); err = '0; beat = '1;
        chk("R4", "idle err ignored faulty_map", faulty_map, 0);
        chk("R4", "idle err ignored sel_a", sel_a, 0);
        pair_req = 1'b1; step(); step(); pair_req = 1'b0;
        chk("R11", "late pair request ignored", pair_active, 0);
        err[0] = 1'b1; #1;
        chk("R10", "valid low during fault", sys_valid, 0);
        step(); err = '0;
        chk("R3", "moved to module 1", sel_a, 1);
        chk("R3", "module 0 marked", faulty_map, 5'b00001);
        chk("R12", "reconfig pulse high", reconfig, 1);
        step();
        chk("R12", "reconfig pulse ends", reconfig, 0);
        // watchdog: one cycle short of the timeout
        beat[1] = 1'b0; repeat (T - 1) step();
        beat[1] = 1'b1; step();
        chk("R5", "heartbeat in time keeps module", sel_a, 1);
        beat[1] = 1'b0; repeat (T) step();
        chk("R5", "expiry shows as invalid", sys_valid, 0);
        chk("R5", "not yet retired", sel_a, 1);
        step(); beat = '1;
        chk("R5", "retired after timeout", sel_a, 2);
        err[2] = 1'b1; step(); err = '0;
        err[3] = 1'b1; step(); err = '0;
        chk("R3", "skips to module 4", sel_a, 4);
        err[4] = 1'b1; step(); err = '0;
        chk("R9", "failed flag", sys_failed, 1);
        chk("R9", "no module running", mod_run, 0);
        chk("R9", "data zero", sys_data, 0);
        err = '1; step(); step(); err = '0;
        chk("R9", "failed holds", sys_failed, 1);
        chk("R6", "all marked", faulty_map, 5'b11111);
        // ---- pair run ----
        for (int i = 0; i < N; i++) data[i*W +: W] = 8'h5A;
        do_reset(1'b1);
        chk("R1", "pair after reset", pair_active, 1);
        chk("R1", "pair sel_b", sel_b, 1);
        chk("R6", "reset clears marks", faulty_map, 0);
        for (int k = 0; k < 3; k++) begin
            for (int i = 0; i < N; i++) data[i*W +: W] = W'(8'h30 + k);
            step();
            chk("R7", "matching pair valid", sys_valid, 1);
        end
        data[1*W +: W] = data[1*W +: W] ^ 8'h01; #1;
        chk("R10", "mismatch invalid", sys_valid, 0);
        step(); data[1*W +: W] = data[0*W +: W];
        chk("R7", "new pair sel_a", sel_a, 2);
        chk("R7", "new pair sel_b", sel_b, 3);
        chk("R7", "both marked", faulty_map, 5'b00011);
        beat[3] = 1'b0; repeat (T + 1) step(); beat = '1;
        chk("R8", "fall back to simplex", pair_active, 0);
        chk("R8", "last module", sel_a, 4);
        chk("R8", "pair marked", faulty_map, 5'b01111);
        err[4] = 1'b1; step(); err = '0;
        chk("R9", "pair path failed", sys_failed, 1);
        step();
        report();
    end
endmodule